// File: doc/BRIEF.md
# Table jump instruction expander

This block sits right after the compressed-instruction decoder of a small 32-bit core that has no address translation. The upstream decoder flags a compressed table-jump instruction: bits [1:0] = 2'b10, [15:13] = 3'b101 and [12:10] = 3'b000. It leaves that instruction neither expanded nor marked illegal. The expander takes the instruction word, the current PC and the jump-table base register. It computes the address of the selected table entry and reads the entry through a data-cache request/grant/valid port. It then hands the main decoder an uncompressed JAL that reaches the entry's target.

Fetch is stalled for the whole time the read is outstanding. Upstream must hold the instruction, PC and base register steady while `fetch_stall_o` is high. The request side follows the cache's back-pressure: the request and its address are held until `mem_gnt_i`, and no second request is issued before the data strobe returns. The instruction path is a plain decode stage: whatever is presented in a cycle with the stall low is taken by the next stage. Any instruction that is not flagged passes straight through.

Top module: `tjx_expander`

## Requirements
- R1: When `is_tj_i` is low, `instr_o`, `illegal_o` and `compressed_o` equal `instr_i`, `illegal_i` and `compressed_i` in the same cycle, with `fetch_stall_o` and `mem_req_o` low.
- R2: For a flagged instruction the table index is `instr_i[9:2]`. The entry address on `mem_addr_o` is the base register with its low 6 bits cleared, plus the index times 4.
- R3: A nonzero mode field (base register bits [5:0]) makes a flagged instruction illegal at once. `illegal_o` = 1, `instr_o` = `instr_i`, `compressed_o` = 1, and no request or stall is raised.
- R4: `mem_req_o` rises in the cycle a valid flagged instruction is presented. It stays high with an unchanged address until the cycle in which `mem_gnt_i` is high.
- R5: `fetch_stall_o` is high from acceptance until the cycle in which `mem_rvalid_i` returns the entry. It is low in that cycle, and the replacement is presented in that same cycle.
- R6: The replacement is a JAL: opcode 7'b1101111, with offset = entry − PC. Bits [31:12] hold offset bits {20, 10:1, 11, 19:12}, in that order.
- R7: Index values 0 to 31 give rd = x0 (bits [11:7] = 0). Index values 32 to 255 give rd = x1 (bits [11:7] = 1).
- R8: For every flagged instruction, `compressed_o` is 1, so the link value is PC+2.
- R9: If entry − PC is odd, or lies outside the signed 21-bit range, then `illegal_o` = 1 and `instr_o` = `instr_i` in the data cycle.
- R10: While `rst_ni` is low, `mem_req_o` and `fetch_stall_o` are low, and the controller returns to its idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction from the compressed decoder |
| pc_i | input | XLEN | PC of that instruction |
| is_tj_i | input | 1 | Instruction is a table jump |
| illegal_i | input | 1 | Upstream illegal flag |
| compressed_i | input | 1 | Upstream compressed flag |
| jvt_i | input | XLEN | Jump-table base register (base in upper bits, mode in [5:0]) |
| mem_req_o | output | 1 | Entry read request |
| mem_addr_o | output | XLEN | Entry address |
| mem_gnt_i | input | 1 | Cache accepted the request |
| mem_rvalid_i | input | 1 | Entry data valid |
| mem_rdata_i | input | XLEN | Entry data |
| instr_o | output | 32 | Instruction to the main decoder |
| illegal_o | output | 1 | Illegal flag to the main decoder |
| compressed_o | output | 1 | Compressed flag to the main decoder |
| fetch_stall_o | output | 1 | Hold fetch |

## Verification
The hardest situation to reach is the handoff between the two sides of the handshake. That means a grant that arrives only after several refused cycles, followed by a data strobe that arrives late, all while the upstream holds the same instruction. The bench drives the cache port as a responder with random grant and data latencies of zero to three cycles. It checks the request, the address and the stall in every waiting cycle. Directed cases cover the index split at 31 and 32, the extreme reachable offsets, and targets just out of range or odd.

// File: rtl/tjx_pkg.sv
package tjx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } tjx_state_e;

  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [4:0] REG_ZERO  = 5'd0;
  localparam logic [4:0] REG_RA    = 5'd1;
  localparam int         JOFF_W    = 21;
endpackage

// File: rtl/tjx_addr_gen.sv
module tjx_addr_gen #(
  parameter int XLEN     = 32,
  parameter int IDX_W    = 8,
  parameter int MODE_W   = 6,
  parameter int LINK_MIN = 32
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  base_i,
  output logic [XLEN-1:0]  addr_o,
  output logic             mode_bad_o,
  output logic             link_o
);
  localparam int ENTRY_SHIFT = $clog2(XLEN / 8);

  logic [XLEN-1:0] base_aligned;
  logic [XLEN-1:0] offset;

  always_comb begin
    base_aligned = {base_i[XLEN-1:MODE_W], {MODE_W{1'b0}}};
    offset       = XLEN'(idx_i) << ENTRY_SHIFT;
    addr_o       = base_aligned + offset;
    mode_bad_o   = |base_i[MODE_W-1:0];
    link_o       = (int'(idx_i) >= LINK_MIN);
  end
endmodule

// File: rtl/tjx_ctrl.sv
module tjx_ctrl
  import tjx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic gnt_i,
  input  logic rvalid_i,
  output logic req_o,
  output logic stall_o,
  output logic done_o
);
  tjx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    req_o   = 1'b0;
    stall_o = 1'b0;
    done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_o   = start_i;
        stall_o = start_i;
        if (start_i && gnt_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        stall_o = !rvalid_i;
        done_o  = rvalid_i;
        if (rvalid_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (!rst_ni) begin
      req_o   = 1'b0;
      stall_o = 1'b0;
      done_o  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/tjx_jal_build.sv
module tjx_jal_build
  import tjx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] entry_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            link_i,
  output logic [31:0]     jal_o,
  output logic            bad_o
);
  logic [XLEN-1:0] off;
  logic            in_range;

  always_comb begin
    off      = entry_i - pc_i;
    in_range = (off[XLEN-1:JOFF_W-1] == {(XLEN-JOFF_W+1){off[JOFF_W-1]}});
    bad_o    = !in_range || off[0];
    jal_o    = {off[20], off[10:1], off[11], off[19:12],
                (link_i ? REG_RA : REG_ZERO), OPC_JAL};
  end
endmodule

// File: rtl/tjx_expander.sv
module tjx_expander
  import tjx_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IDX_W    = 8,
  parameter int MODE_W   = 6,
  parameter int LINK_MIN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            is_tj_i,
  input  logic            illegal_i,
  input  logic            compressed_i,
  input  logic [XLEN-1:0] jvt_i,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  input  logic            mem_gnt_i,
  input  logic            mem_rvalid_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic [31:0]     instr_o,
  output logic            illegal_o,
  output logic            compressed_o,
  output logic            fetch_stall_o
);
  localparam int IDX_LSB = 2;

  logic [IDX_W-1:0] idx;
  logic             mode_bad;
  logic             link;
  logic             start;
  logic             done;
  logic [31:0]      jal_word;
  logic             jal_bad;

  assign idx = instr_i[IDX_LSB +: IDX_W];

  tjx_addr_gen #(
    .XLEN(XLEN), .IDX_W(IDX_W), .MODE_W(MODE_W), .LINK_MIN(LINK_MIN)
  ) u_addr (
    .idx_i      (idx),
    .base_i     (jvt_i),
    .addr_o     (mem_addr_o),
    .mode_bad_o (mode_bad),
    .link_o     (link)
  );

  assign start = is_tj_i && !mode_bad;

  tjx_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .gnt_i    (mem_gnt_i),
    .rvalid_i (mem_rvalid_i),
    .req_o    (mem_req_o),
    .stall_o  (fetch_stall_o),
    .done_o   (done)
  );

  tjx_jal_build #(.XLEN(XLEN)) u_jal (
    .entry_i (mem_rdata_i),
    .pc_i    (pc_i),
    .link_i  (link),
    .jal_o   (jal_word),
    .bad_o   (jal_bad)
  );

  always_comb begin
    instr_o      = instr_i;
    illegal_o    = illegal_i;
    compressed_o = compressed_i;
    if (is_tj_i) begin
      compressed_o = 1'b1;
      illegal_o    = 1'b0;
      if (mode_bad) begin
        illegal_o = 1'b1;
      end else if (done) begin
        if (jal_bad) illegal_o = 1'b1;
        else         instr_o   = jal_word;
      end
    end
  end
endmodule

// File: rtl/tjx_expander_chk.sv
module tjx_expander_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [31:0]     instr_i,
  input logic            is_tj_i,
  input logic [XLEN-1:0] jvt_i,
  input logic            mem_req_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            mem_gnt_i,
  input logic            mem_rvalid_i,
  input logic [31:0]     instr_o,
  input logic            illegal_o,
  input logic            compressed_o,
  input logic            fetch_stall_o
);
  a_r1_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_tj_i |-> (instr_o == instr_i) && !fetch_stall_o && !mem_req_o);

  a_r3_mode_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_tj_i && (jvt_i[5:0] != 6'd0)) |-> !mem_req_o && illegal_o);

  a_r4_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && is_tj_i) |=> mem_req_o && $stable(mem_addr_o));

  a_r5_stall_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i) |=> (fetch_stall_o || mem_rvalid_i) && !mem_req_o);

  a_r7_rd_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_tj_i && !fetch_stall_o && !illegal_o) |->
      (instr_o[6:0] == 7'b1101111) &&
      (instr_o[11:7] == ((instr_i[9:2] >= 8'd32) ? 5'd1 : 5'd0)));

  a_r8_compressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_tj_i |-> compressed_o);

  always_comb begin
    if (!rst_ni) a_r10_reset_quiet: assert (!mem_req_o && !fetch_stall_o);
  end
endmodule

bind tjx_expander tjx_expander_chk #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_i       (instr_i),
  .is_tj_i       (is_tj_i),
  .jvt_i         (jvt_i),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_gnt_i     (mem_gnt_i),
  .mem_rvalid_i  (mem_rvalid_i),
  .instr_o       (instr_o),
  .illegal_o     (illegal_o),
  .compressed_o  (compressed_o),
  .fetch_stall_o (fetch_stall_o)
);

// File: tb/tjx_expander_tb_top.sv
module tjx_expander_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] pc_i = '0;
  logic        is_tj_i = 1'b0;
  logic        illegal_i = 1'b0;
  logic        compressed_i = 1'b0;
  logic [31:0] jvt_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_gnt_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] instr_o;
  logic        illegal_o;
  logic        compressed_o;
  logic        fetch_stall_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  tjx_expander dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [7:0] idx);
    return {base[31:6], 6'd0} + {22'd0, idx, 2'b00};
  endfunction

  function automatic logic [31:0] exp_jal(input logic [31:0] off, input logic [7:0] idx);
    logic [4:0] rd;
    rd = (idx >= 8'd32) ? 5'd1 : 5'd0;
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
  endfunction

  function automatic bit off_ok(input logic [31:0] off);
    return !off[0] && ($signed(off) >= -32'sd1048576) && ($signed(off) <= 32'sd1048574);
  endfunction

  task automatic run_pass(input logic [31:0] w, input bit il, input bit cp);
    @(negedge clk_i);
    instr_i = w; illegal_i = il; compressed_i = cp; is_tj_i = 1'b0;
    #1;
    chk(instr_o == w, "R1 instr", instr_o, w);
    chk(illegal_o == il && compressed_o == cp, "R1 flags",
        {30'd0, illegal_o, compressed_o}, {30'd0, il, cp});
    chk(!fetch_stall_o && !mem_req_o, "R1 no stall/req",
        {30'd0, fetch_stall_o, mem_req_o}, 32'd0);
  endtask

  task automatic run_tj(input logic [7:0] idx, input logic [31:0] base,
                        input logic [5:0] mode, input logic [31:0] pc,
                        input logic [31:0] entry, input int gd, input int rd);
    logic [31:0] w, ea, off;
    w = {16'd0, 3'b101, 3'b000, idx, 2'b10};
    ea = exp_addr(base, idx);
    @(negedge clk_i);
    instr_i = w; is_tj_i = 1'b1; illegal_i = 1'b0; compressed_i = 1'b1;
    jvt_i = {base[31:6], mode}; pc_i = pc;
    mem_gnt_i = 1'b0; mem_rvalid_i = 1'b0;
    #1;
    if (mode != 6'd0) begin
      chk(illegal_o && instr_o == w, "R3 illegal mode", instr_o, w);
      chk(!mem_req_o && !fetch_stall_o, "R3 no read",
          {30'd0, mem_req_o, fetch_stall_o}, 32'd0);
      @(negedge clk_i);
      is_tj_i = 1'b0;
      return;
    end
    chk(mem_req_o && fetch_stall_o, "R4 R5 accept", {30'd0, mem_req_o, fetch_stall_o}, 32'd3);
    chk(mem_addr_o == ea, "R2 address", mem_addr_o, ea);
    for (int k = 0; k < gd; k++) begin
      @(negedge clk_i); #1;
      chk(mem_req_o && mem_addr_o == ea, "R4 held", mem_addr_o, ea);
    end
    @(negedge clk_i);
    mem_gnt_i = 1'b1;
    @(negedge clk_i);
    mem_gnt_i = 1'b0;
    #1;
    chk(!mem_req_o && fetch_stall_o, "R5 waiting", {30'd0, mem_req_o, fetch_stall_o}, 32'd1);
    for (int k = 0; k < rd; k++) begin
      @(negedge clk_i); #1;
      chk(fetch_stall_o, "R5 stall hold", {31'd0, fetch_stall_o}, 32'd1);
    end
    @(negedge clk_i);
    mem_rvalid_i = 1'b1; mem_rdata_i = entry;
    #1;
    off = entry - pc;
    chk(!fetch_stall_o, "R5 stall release", {31'd0, fetch_stall_o}, 32'd0);
    chk(compressed_o, "R8 compressed", {31'd0, compressed_o}, 32'd1);
    if (off_ok(off)) begin
      chk(!illegal_o && instr_o == exp_jal(off, idx), "R6 R7 jal", instr_o, exp_jal(off, idx));
    end else begin
      chk(illegal_o && instr_o == w, "R9 bad offset", instr_o, w);
    end
    @(negedge clk_i);
    mem_rvalid_i = 1'b0; is_tj_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    is_tj_i = 1'b1;
    #3;
    chk(!mem_req_o && !fetch_stall_o, "R10 reset quiet",
        {30'd0, mem_req_o, fetch_stall_o}, 32'd0);
    is_tj_i = 1'b0;
    #20 rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(!mem_req_o && !fetch_stall_o, "R10 after reset",
        {30'd0, mem_req_o, fetch_stall_o}, 32'd0);

    // directed corners
    run_tj(8'd31,  32'h0001_0040, 6'd0, 32'h0000_2000, 32'h0000_3000, 0, 0);
    run_tj(8'd32,  32'h0001_0040, 6'd0, 32'h0000_2000, 32'h0000_1000, 2, 3);
    run_tj(8'd0,   32'h0002_007F, 6'd0, 32'h0000_8000, 32'h0000_8000, 1, 1);
    run_tj(8'd255, 32'hFFFF_FFC0, 6'd0, 32'h0010_0000, 32'h0020_0000 - 32'd2, 3, 0);
    run_tj(8'd40,  32'h0001_0000, 6'd0, 32'h0010_0000, 32'h0000_0000, 0, 2);
    run_tj(8'd40,  32'h0001_0000, 6'd0, 32'h0010_0000, 32'h0020_0000, 0, 0);
    run_tj(8'd5,   32'h0001_0000, 6'd0, 32'h0010_0000, 32'h0000_0000 - 32'd2, 1, 0);
    run_tj(8'd6,   32'h0001_0000, 6'd0, 32'h0010_0000, 32'h0010_0001, 0, 0);
    run_tj(8'd7,   32'h0001_0000, 6'd1, 32'h0010_0000, 32'h0010_0100, 0, 0);
    run_tj(8'd60,  32'h0001_0000, 6'd32, 32'h0010_0000, 32'h0010_0100, 0, 0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 2) == 0) begin
        run_pass($urandom(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end else begin
        logic [31:0] pc, entry, delta;
        logic [5:0]  md;
        pc = {$urandom()} & 32'hFFFF_FFFE;
        delta = ($urandom_range(0, 9) == 0) ? $urandom()
              : {{11{1'b0}}, 21'($urandom())} - 32'h0010_0000;
        entry = pc + (delta & 32'hFFFF_FFFE);
        md = ($urandom_range(0, 7) == 0) ? 6'($urandom_range(1, 63)) : 6'd0;
        run_tj(8'($urandom()), $urandom(), md, pc, entry,
               $urandom_range(0, 3), $urandom_range(0, 3));
      end
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual %h expected %h", 32'd1, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule